// File: doc/BRIEF.md
# Host-to-DSP Memory Access Mailbox

This block lets a host processor reach single words of a DSP's internal RAM through a handful of byte-wide registers. The host programs a direction bit, a split word address (high byte, low byte and an extension bit kept in a configuration register), and, for a write, the two data bytes. It then sets a go bit. The block issues one request on the DSP-side memory port and waits for the acknowledge. On a read, it places the returned word in the data registers. It then clears the go bit itself and sets a sticky completion flag.

When interrupts are enabled, the completion also sets an interrupt-active bit and raises `irq`. The host clears both bits by writing 0 to the completion flag. `irq` stays high while an external source is still pending. Parameters, programming registers and data stay frozen while a transfer is outstanding, so the DSP sees a stable request.

Top module: `hdm_bridge`

Register offsets: 0 command (bit0 go/busy, bit1 direction), 1 address high, 2 address low, 3 data high, 4 data low, 5 status (bit0 done, bit1 interrupt active), 6 configuration (bit0 interrupt enable, bit1 address extension). Unused bits read as 0.

## Requirements
- R1: After reset, all registers read 0, `dsp_req` is low, and `irq` equals `ext_irq_pend`.
- R2: A host write to offsets 1, 2, 3, 4 or 6 while idle stores the byte. A write to offset 0 with bit0 = 0 stores only the direction bit. A read strobe returns the selected register on `hst_rdata` one clock later.
- R3: Writing offset 0 with bit0 = 1 while idle makes `dsp_req` high for exactly one cycle, in the cycle after the write. During that cycle `dsp_addr` = {extension, address high, address low}, `dsp_we` = direction bit (1 = write, 0 = read), and `dsp_wdata` = {data high, data low}.
- R4: A `dsp_ack` while a transfer is outstanding ends it. Command bit0 then reads 0 and status bit0 reads 1.
- R5: On completion of a read, `dsp_rdata[15:8]` is loaded into data high and `dsp_rdata[7:0]` into data low.
- R6: While a transfer is outstanding, host writes to offsets 0 to 4 and to the extension bit are ignored, and no second request is issued.
- R7: If interrupt enable is 1 at completion, status bit1 sets and `irq` rises the cycle after the acknowledge. If it is 0, status bit1 stays 0.
- R8: Writing offset 5 with bit0 = 0 clears done and interrupt active. Writing bit0 = 1 has no effect. A completion in the same cycle as the clear wins.
- R9: `irq` is high whenever interrupt active or `ext_irq_pend` is high, and low otherwise.
- R10: A `dsp_ack` with no transfer outstanding changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 3 | Host register offset |
| hst_wdata | input | 8 | Host write byte |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_rdata | output | 8 | Registered host read byte |
| ext_irq_pend | input | 1 | Other interrupt source pending |
| irq | output | 1 | Interrupt to host |
| dsp_req | output | 1 | One-cycle memory request |
| dsp_we | output | 1 | Request is a write |
| dsp_addr | output | 17 | Word address |
| dsp_wdata | output | 16 | Write word |
| dsp_ack | input | 1 | Memory acknowledge pulse |
| dsp_rdata | input | 16 | Read word, valid with acknowledge |

## Verification
A stuck or lost busy state shows up at the ports within a cycle or two. It appears as a missing or repeated `dsp_req` pulse, or as a go bit that never clears, on the next status read. Corrupted address or data holding registers appear as a wrong `dsp_addr` or `dsp_wdata` on the request cycle, or as a wrong readback after an ignored write. A wrong completion flag or interrupt-active bit shows up on the next status read and on `irq` one cycle after the acknowledge. The sweep varies direction, enable, extension bit, address, data and acknowledge delay across many transfers, so each of these faults is exercised.

// File: rtl/hdm_pkg.sv
// Shared register offsets and bit positions for the host-to-DSP mailbox.
// Assumes a host offset field of 3 bits.
package hdm_pkg;
    typedef enum logic [2:0] {
        OFS_CMD  = 3'd0,
        OFS_ADH  = 3'd1,
        OFS_ADL  = 3'd2,
        OFS_DTH  = 3'd3,
        OFS_DTL  = 3'd4,
        OFS_STAT = 3'd5,
        OFS_CFG  = 3'd6
    } ofs_e;

    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_DIR_BIT  = 1;
    localparam int STAT_DN_BIT  = 0;
    localparam int STAT_IA_BIT  = 1;
    localparam int CFG_IEN_BIT  = 0;
    localparam int CFG_EXT_BIT  = 1;
endpackage

// File: rtl/hdm_regfile.sv
// Host-visible holding registers (direction, address, data, configuration)
// and the registered read mux. Assumes busy blocks all writes that feed the
// DSP request, so data-register loads from a read completion never collide
// with host writes.
module hdm_regfile
    import hdm_pkg::*;
#(
    parameter int HBW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       hst_addr,
    input  logic [HBW-1:0]   hst_wdata,
    input  logic             hst_wr,
    input  logic             hst_rd,
    input  logic             busy,
    input  logic             ld_rd,
    input  logic [2*HBW-1:0] rd_word,
    input  logic             done,
    input  logic             iact,
    output logic [HBW-1:0]   adh,
    output logic [HBW-1:0]   adl,
    output logic [HBW-1:0]   dth,
    output logic [HBW-1:0]   dtl,
    output logic             dir,
    output logic             ien,
    output logic             aext,
    output logic [HBW-1:0]   hst_rdata
);
    logic           wr_ok;
    logic [HBW-1:0] rd_mux;

    assign wr_ok = hst_wr && !busy;

    // Address, direction and extension: host writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adh  <= '0;
            adl  <= '0;
            dir  <= 1'b0;
            aext <= 1'b0;
            ien  <= 1'b0;
        end else begin
            if (wr_ok && hst_addr == OFS_ADH) adh <= hst_wdata;
            if (wr_ok && hst_addr == OFS_ADL) adl <= hst_wdata;
            if (wr_ok && hst_addr == OFS_CMD) dir <= hst_wdata[CMD_DIR_BIT];
            if (wr_ok && hst_addr == OFS_CFG) aext <= hst_wdata[CFG_EXT_BIT];
            if (hst_wr && hst_addr == OFS_CFG) ien <= hst_wdata[CFG_IEN_BIT];
        end
    end

    // Data bytes: loaded by the host while idle or by a read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dth <= '0;
            dtl <= '0;
        end else if (ld_rd) begin
            dth <= rd_word[2*HBW-1:HBW];
            dtl <= rd_word[HBW-1:0];
        end else begin
            if (wr_ok && hst_addr == OFS_DTH) dth <= hst_wdata;
            if (wr_ok && hst_addr == OFS_DTL) dtl <= hst_wdata;
        end
    end

    // Select the register addressed by the host.
    always_comb begin
        rd_mux = '0;
        case (hst_addr)
            OFS_CMD: begin
                rd_mux[CMD_GO_BIT]  = busy;
                rd_mux[CMD_DIR_BIT] = dir;
            end
            OFS_ADH: rd_mux = adh;
            OFS_ADL: rd_mux = adl;
            OFS_DTH: rd_mux = dth;
            OFS_DTL: rd_mux = dtl;
            OFS_STAT: begin
                rd_mux[STAT_DN_BIT] = done;
                rd_mux[STAT_IA_BIT] = iact;
            end
            OFS_CFG: begin
                rd_mux[CFG_IEN_BIT] = ien;
                rd_mux[CFG_EXT_BIT] = aext;
            end
            default: rd_mux = '0;
        endcase
    end

    // Register the read byte on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      hst_rdata <= '0;
        else if (hst_rd) hst_rdata <= rd_mux;
    end
endmodule

// File: rtl/hdm_xfer.sv
// Request/acknowledge sequencer. A go write while idle starts one transfer:
// a single-cycle request pulse, then a wait for the acknowledge. Assumes the
// DSP returns exactly one acknowledge per request, in any later or same cycle.
module hdm_xfer (
    input  logic clk,
    input  logic rst_n,
    input  logic go_wr,
    input  logic dir,
    input  logic dsp_ack,
    output logic busy,
    output logic dsp_req,
    output logic fin,
    output logic ld_rd
);
    logic start;

    assign start = go_wr && !busy;
    assign fin   = busy && dsp_ack;
    assign ld_rd = fin && !dir;

    // Track the outstanding transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (fin)   busy <= 1'b0;
    end

    // Issue the one-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) dsp_req <= 1'b0;
        else        dsp_req <= start;
    end
endmodule

// File: rtl/hdm_status.sv
// Sticky completion flag and interrupt-active bit. Assumes a completion and a
// host clear in the same cycle resolve in favour of the completion.
module hdm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    input  logic ien,
    input  logic clr,
    output logic done,
    output logic iact
);
    // Completion flag: set by a finished transfer, cleared by a host write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n)   done <= 1'b0;
        else if (fin) done <= 1'b1;
        else if (clr) done <= 1'b0;
    end

    // Interrupt-active bit: set on an enabled completion, cleared with done.
    always_ff @(posedge clk) begin
        if (!rst_n)          iact <= 1'b0;
        else if (fin && ien) iact <= 1'b1;
        else if (clr && !fin) iact <= 1'b0;
    end
endmodule

// File: rtl/hdm_bridge.sv
// Top of the host-to-DSP memory mailbox: host register file, transfer
// sequencer and status/interrupt logic. Assumes a synchronous byte-wide host
// bus and a pulse-based DSP memory port with one request outstanding.
module hdm_bridge
    import hdm_pkg::*;
#(
    parameter int HBW = 8,
    localparam int DW = 2 * HBW,
    localparam int AW = 2 * HBW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     hst_addr,
    input  logic [HBW-1:0] hst_wdata,
    input  logic           hst_wr,
    input  logic           hst_rd,
    output logic [HBW-1:0] hst_rdata,
    input  logic           ext_irq_pend,
    output logic           irq,
    output logic           dsp_req,
    output logic           dsp_we,
    output logic [AW-1:0]  dsp_addr,
    output logic [DW-1:0]  dsp_wdata,
    input  logic           dsp_ack,
    input  logic [DW-1:0]  dsp_rdata
);
    logic [HBW-1:0] adh, adl, dth, dtl;
    logic dir, ien, aext;
    logic busy, fin, ld_rd, done, iact;
    logic go_wr, clr;

    assign go_wr = hst_wr && hst_addr == OFS_CMD && hst_wdata[CMD_GO_BIT];
    assign clr   = hst_wr && hst_addr == OFS_STAT && !hst_wdata[STAT_DN_BIT];

    hdm_regfile #(.HBW(HBW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .busy(busy), .ld_rd(ld_rd),
        .rd_word(dsp_rdata), .done(done), .iact(iact), .adh(adh), .adl(adl),
        .dth(dth), .dtl(dtl), .dir(dir), .ien(ien), .aext(aext),
        .hst_rdata(hst_rdata)
    );

    hdm_xfer u_xfer (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .dir(dir), .dsp_ack(dsp_ack),
        .busy(busy), .dsp_req(dsp_req), .fin(fin), .ld_rd(ld_rd)
    );

    hdm_status u_stat (
        .clk(clk), .rst_n(rst_n), .fin(fin), .ien(ien), .clr(clr),
        .done(done), .iact(iact)
    );

    assign dsp_we    = dir;
    assign dsp_addr  = {aext, adh, adl};
    assign dsp_wdata = {dth, dtl};
    assign irq       = iact || ext_irq_pend;
endmodule

// File: rtl/hdm_bridge_chk.sv
// Assertion checker for hdm_bridge, attached by bind below.
module hdm_bridge_chk #(
    parameter int HBW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsp_req,
    input logic             dsp_ack,
    input logic             dsp_we,
    input logic [2*HBW:0]   dsp_addr,
    input logic [2*HBW-1:0] dsp_wdata,
    input logic [2*HBW-1:0] dsp_rdata,
    input logic             busy,
    input logic             done,
    input logic             iact,
    input logic             ien,
    input logic             irq
);
    // R3: the request is a single-cycle pulse
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_req |=> !dsp_req);

    // R6: address held while a transfer is outstanding
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dsp_addr));

    // R4: acknowledge ends the transfer and sets done
    a_r4_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dsp_ack) |=> (!busy && done));

    // R5: read completion loads the data registers
    a_r5_read_load: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dsp_ack && !dsp_we) |=> (dsp_wdata == $past(dsp_rdata)));

    // R7: enabled completion raises irq
    a_r7_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dsp_ack && ien) |=> irq);

    // R8: interrupt active never outlives done
    a_r8_iact_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        iact |-> done);
endmodule

bind hdm_bridge hdm_bridge_chk #(.HBW(HBW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dsp_req(dsp_req), .dsp_ack(dsp_ack),
    .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
    .dsp_rdata(dsp_rdata), .busy(busy), .done(done), .iact(iact),
    .ien(ien), .irq(irq)
);

// File: tb/hdm_bridge_tb.sv
`timescale 1ns/1ps
module hdm_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [7:0]  hst_rdata;
    logic        ext_irq_pend = 1'b0;
    logic        irq;
    logic        dsp_req;
    logic        dsp_we;
    logic [16:0] dsp_addr;
    logic [15:0] dsp_wdata;
    logic        dsp_ack = 1'b0;
    logic [15:0] dsp_rdata = '0;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hdm_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_rdata(hst_rdata),
        .ext_irq_pend(ext_irq_pend), .irq(irq), .dsp_req(dsp_req),
        .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
        .dsp_ack(dsp_ack), .dsp_rdata(dsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic ack_cycle(input logic [15:0] rd);
        @(negedge clk);
        dsp_ack = 1'b1; dsp_rdata = rd;
        @(negedge clk);
        dsp_ack = 1'b0;
    endtask

    // One full transfer with protected-write probes and status checks.
    task automatic xfer(input int i);
        logic [7:0] ah, al, dh, dl, v;
        logic we, ien, ext;
        logic [15:0] rw;
        int dly;
        we  = i[0]; ien = i[1]; ext = i[2];
        ah  = 8'((i * 37 + 5) & 255);
        al  = 8'((i * 91 + 3) & 255);
        dh  = 8'((i * 13) ^ 8'hA5);
        dl  = 8'(i * 29 + 1);
        rw  = {al ^ 8'h3C, 8'(ah + i)};
        dly = i % 4;
        hwr(3'd6, {6'd0, ext, ien});
        hwr(3'd1, ah);
        hwr(3'd2, al);
        hwr(3'd3, dh);
        hwr(3'd4, dl);
        hwr(3'd0, {6'd0, we, 1'b1});
        chk(dsp_req === 1'b1, "R3 req pulse", int'(dsp_req), 1);
        chk(dsp_addr === {ext, ah, al}, "R3 address", int'(dsp_addr), int'({ext, ah, al}));
        chk(dsp_we === we, "R3 direction", int'(dsp_we), int'(we));
        chk(dsp_wdata === {dh, dl}, "R3 write data", int'(dsp_wdata), int'({dh, dl}));
        hwr(3'd2, ~al);
        chk(dsp_req === 1'b0, "R3 pulse width", int'(dsp_req), 0);
        hwr(3'd0, 8'h03);
        chk(dsp_req === 1'b0, "R6 no second request", int'(dsp_req), 0);
        hwr(3'd3, ~dh);
        hwr(3'd6, {6'd0, ~ext, ien});
        repeat (dly) @(negedge clk);
        hrd(3'd0, v);
        chk(v[0] === 1'b1, "R4 busy before ack", int'(v), 1);
        ack_cycle(rw);
        chk(irq === ien, "R7 irq after ack", int'(irq), int'(ien));
        hrd(3'd0, v);
        chk(v === {6'd0, we, 1'b0}, "R4 go cleared", int'(v), int'({we, 1'b0}));
        hrd(3'd5, v);
        chk(v === {6'd0, ien, 1'b1}, "R7 status", int'(v), int'({ien, 1'b1}));
        chk(dsp_addr === {ext, ah, al}, "R6 address kept", int'(dsp_addr), int'({ext, ah, al}));
        if (we)
            chk(dsp_wdata === {dh, dl}, "R6 data kept", int'(dsp_wdata), int'({dh, dl}));
        else begin
            hrd(3'd3, v);
            chk(v === rw[15:8], "R5 data high", int'(v), int'(rw[15:8]));
            hrd(3'd4, v);
            chk(v === rw[7:0], "R5 data low", int'(v), int'(rw[7:0]));
        end
        hwr(3'd5, 8'h00);
        hrd(3'd5, v);
        chk(v === 8'h00 && irq === 1'b0, "R8 clear", int'(v), 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            hrd(3'(a), v);
            chk(v === 8'h00, "R1 reset register", int'(v), 0);
        end
        chk(dsp_req === 1'b0 && irq === 1'b0, "R1 reset outputs", int'({dsp_req, irq}), 0);
        // R2 readback sweep
        for (int k = 0; k < 16; k++) begin
            logic [7:0] p;
            p = 8'((k * 53 + 11) & 255);
            hwr(3'd1, p);  hrd(3'd1, v); chk(v === p, "R2 addr high", int'(v), int'(p));
            hwr(3'd2, ~p); hrd(3'd2, v); chk(v === ~p, "R2 addr low", int'(v), int'(~p));
            hwr(3'd3, p ^ 8'h5A); hrd(3'd3, v); chk(v === (p ^ 8'h5A), "R2 data high", int'(v), int'(p ^ 8'h5A));
            hwr(3'd4, p + 8'd7); hrd(3'd4, v); chk(v === p + 8'd7, "R2 data low", int'(v), int'(p + 8'd7));
            hwr(3'd6, p); hrd(3'd6, v); chk(v === {6'd0, p[1:0]}, "R2 config", int'(v), int'(p[1:0]));
            hwr(3'd0, {p[7:1], 1'b0}); hrd(3'd0, v);
            chk(v === {6'd0, p[1], 1'b0} && dsp_req === 1'b0, "R2 command dir only", int'(v), int'(p[1] << 1));
        end
        // Main sweep: direction, enable, extension, address, data, ack delay
        for (int i = 0; i < 48; i++) xfer(i);
        // R10: idle acknowledge changes nothing
        hwr(3'd3, 8'h11); hwr(3'd4, 8'h22);
        ack_cycle(16'hBEEF);
        hrd(3'd5, v); chk(v === 8'h00, "R10 status unchanged", int'(v), 0);
        hrd(3'd3, v); chk(v === 8'h11, "R10 data high unchanged", int'(v), 8'h11);
        hrd(3'd4, v); chk(v === 8'h22, "R10 data low unchanged", int'(v), 8'h22);
        // R8: writing 1 to done has no effect
        hwr(3'd5, 8'h03);
        hrd(3'd5, v); chk(v === 8'h00, "R8 write one ignored", int'(v), 0);
        // R8: completion beats a clear in the same cycle
        hwr(3'd6, 8'h01);
        hwr(3'd0, 8'h01);
        @(negedge clk);
        hst_addr = 3'd5; hst_wdata = 8'h00; hst_wr = 1'b1;
        dsp_ack = 1'b1; dsp_rdata = 16'h1234;
        @(negedge clk);
        hst_wr = 1'b0; dsp_ack = 1'b0;
        hrd(3'd5, v); chk(v === 8'h03, "R8 set wins", int'(v), 3);
        // R9: external pending keeps irq after clear
        ext_irq_pend = 1'b1;
        hwr(3'd5, 8'h00);
        chk(irq === 1'b1, "R9 irq from external", int'(irq), 1);
        ext_irq_pend = 1'b0;
        @(negedge clk);
        chk(irq === 1'b0, "R9 irq low", int'(irq), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule